// File: doc/BRIEF.md
# Fall-through FIFO over a registered-read RAM

This block is a single-clock first-in first-out buffer whose storage is a two-port RAM: one write port, and one read port whose data arrives one clock after its address. A consumer still sees the oldest stored word on `dout` in any cycle where `empty` is low, and may take it with `pop` in that same cycle. To the consumer, the RAM's read latency does not exist.

Two paths hide that latency. First, the RAM is read every cycle at the address that will be the head after the current edge. That is the read pointer, or the pointer plus one when a pop is accepted. Second, a word written to the address that becomes the head on the same edge cannot come back from the RAM in time. A bypass register catches a copy of it, and the output takes the bypass copy for that one cycle. This case covers a push into an empty buffer and a push together with a pop when one word is held.

Depth and word width are parameters. Pointers wrap at the depth, which does not have to be a power of two. A synchronous flush empties the buffer, and an active-low asynchronous reset does the same.

Top module: `sync_ram_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `count` is 0 and `dout` is 0.
- R2: While `empty` is 0, `dout` shows the oldest stored word, and words leave in the order they were accepted. An accepted pop removes that word at the clock edge.
- R3: A push while `full` is 1 (and no pop is accepted) is dropped. `count` stays the same and no stored word changes.
- R4: A pop while `empty` is 1 is ignored. `count` stays 0, and `dout` reads 0 whenever `empty` is 1.
- R5: A word pushed into an empty FIFO appears on `dout` in the very next cycle and can be popped in that cycle.
- R6: A push and a pop in the same cycle on a FIFO that is neither empty nor full keep `count` unchanged and keep the order, including when only one word is held.
- R7: `flush` empties the FIFO at the next edge, with `count` 0 and `dout` 0. A push or pop in the flush cycle has no effect.
- R8: `full` is 1 exactly when `count` equals DEPTH, and `empty` is 1 exactly when `count` is 0. The pointers wrap modulo DEPTH across repeated fill and drain.
- R9: A push and a pop together while empty accept the push only, so `count` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all contents |
| push | input | 1 | Write request |
| din | input | WIDTH | Write data |
| pop | input | 1 | Read request, takes the word on `dout` |
| dout | output | WIDTH | Head word, 0 when empty |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No word held |
| count | output | $clog2(DEPTH+1) | Number of words held |

## Verification
The hard case is a head word that the RAM has not yet been able to return. It arises from a push into an empty buffer, and from a push together with a pop while exactly one word is held. The bench reaches both on purpose: it writes single words into a drained FIFO, then streams push-with-pop on a one-entry FIFO for several cycles in a row. The pointers sit at varied offsets after earlier fills, so the bypass is also exercised at the wrap point.

// File: rtl/sync_ram_fifo.sv
module sync_ram_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q, byp_q;
  logic             byp_sel_q;
  logic [AW-1:0]    wr_ptr, rd_ptr, rd_next;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rd_next = do_pop ? step_ptr(rd_ptr) : rd_ptr;
  assign dout    = empty ? '0 : (byp_sel_q ? byp_q : rd_q);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  // prefetch: read the address that will be the head after this edge
  always_ff @(posedge clk) begin
    rd_q  <= mem[rd_next];
    byp_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      byp_sel_q <= 1'b0;
    end else if (flush) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      byp_sel_q <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= step_ptr(wr_ptr);
      rd_ptr <= rd_next;
      count  <= count + CW'(do_push) - CW'(do_pop);
      // the RAM read misses a word written this edge at the new head
      byp_sel_q <= do_push && (wr_ptr == rd_next);
    end
  end

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(dout)));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (empty && dout == '0));

  p_first_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push && !flush) |=> (!empty && dout == $past(din)));

  p_steady_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full && push && pop && !flush) |=> $stable(count));

  p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && count == '0 && dout == '0));

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: tb/tb_sync_ram_fifo.sv
module tb_sync_ram_fifo;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, flush = 0, push = 0, pop = 0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic full, empty;
  logic [CW-1:0] count;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [WIDTH-1:0] model[$];

  always #4 clk = ~clk;

  sync_ram_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .din(din),
    .pop(pop), .dout(dout), .full(full), .empty(empty), .count(count));

  task automatic check(input string tag);
    logic [WIDTH-1:0] e_dout;
    int sz;
    sz = model.size();
    e_dout = (sz > 0) ? model[0] : '0;
    n_checks++;
    if (dout !== e_dout || count !== CW'(sz) || empty !== (sz == 0) || full !== (sz == DEPTH)) begin
      n_fail++;
      $display("FAIL %s: dout=%h count=%0d empty=%b full=%b, expected dout=%h count=%0d empty=%b full=%b",
               tag, dout, count, empty, full, e_dout, sz, sz == 0, sz == DEPTH);
    end
  endtask

  task automatic step(input bit p, input bit q, input logic [WIDTH-1:0] d, input bit f, input string tag);
    bit acc_pop, acc_push;
    push = p; pop = q; din = d; flush = f;
    acc_pop  = q && !f && model.size() > 0;
    acc_push = p && !f && model.size() < DEPTH;
    @(posedge clk);
    #1;
    push = 0; pop = 0; flush = 0;
    if (f) model.delete();
    else begin
      if (acc_pop) void'(model.pop_front());
      if (acc_push) model.push_back(d);
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
  endtask

  task automatic t_fill_overflow(input int base);
    for (int i = 0; i < DEPTH; i++) step(1, 0, WIDTH'(base + i), 0, "R8");
    step(1, 0, 16'hdead, 0, "R3");
    step(1, 0, 16'hbeef, 0, "R3");
  endtask

  task automatic t_drain();
    while (model.size() > 0) step(0, 1, '0, 0, "R2");
    step(0, 1, '0, 0, "R4");
    step(0, 1, '0, 0, "R4");
  endtask

  task automatic t_bypass();
    step(1, 0, 16'h1111, 0, "R5");
    step(0, 1, '0, 0, "R5");
    step(1, 0, 16'h2222, 0, "R5");
    step(1, 1, 16'h3333, 0, "R5");
    step(0, 1, '0, 0, "R5");
  endtask

  task automatic t_stream();
    step(1, 0, 16'h0a00, 0, "R6");
    for (int i = 1; i < 7; i++) step(1, 1, WIDTH'(16'h0a00 + i), 0, "R6");
    step(1, 0, 16'h0b00, 0, "R6");
    step(1, 0, 16'h0b01, 0, "R6");
    for (int i = 0; i < 5; i++) step(1, 1, WIDTH'(16'h0c00 + i), 0, "R6");
    t_drain();
  endtask

  task automatic t_empty_pushpop();
    step(1, 1, 16'h7777, 0, "R9");
    step(0, 1, '0, 0, "R9");
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) step(1, 0, WIDTH'(16'h5000 + i), 0, "R7");
    step(1, 1, 16'h9999, 1, "R7");
    step(1, 0, 16'h4242, 0, "R7");
    step(0, 1, '0, 0, "R7");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fill_overflow(16'h0100);
    t_drain();
    t_bypass();
    step(1, 0, 16'h0001, 0, "R8");
    step(1, 0, 16'h0002, 0, "R8");
    step(0, 1, '0, 0, "R8");
    t_fill_overflow(16'h0200);
    t_drain();
    t_stream();
    t_empty_pushpop();
    t_flush();
    t_fill_overflow(16'h0300);
    t_drain();
    t_bypass();
    finish_run();
  end
endmodule